// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer that sits on a small 16-bit register bus. An 8-bit up-counter advances on ticks from a power-of-two prescaler. When the counter steps from 255 back to 0 while watchdog mode is on, a sticky overflow flag is set. If the reset option is armed, a system reset line is then driven high for a fixed number of clock cycles. Software keeps the system alive by reloading the counter before it wraps. It loads 256 minus the number of ticks it wants to allow.

Every write must carry a key in its upper byte, and a write with the wrong key changes nothing. The control register takes key 0xA5. The counter and the reset-configuration register take key 0x5A. The overflow flag is cleared by a separate command: the full word 0xA500 written to the reset register. That command only works after software has read the reset register while the flag was set, so a stray single write cannot hide an overflow. The register at address 0 is control, address 1 is the counter, and address 2 is reset configuration and status.

A parameter selects a 3-bit or a 4-bit divider select. The 3-bit form divides by 2^(2s) for s < 7 and by 16384 for s = 7. The 4-bit form divides by 2^s for s < 15 and by 4194304 for s = 15.

Top module: `kw_watchdog`

## Requirements
- R1: After reset, all three registers read 0x0000 and `wdt_rst` is low.
- R2: A write to address 0 takes effect only when wdata[15:8] is 0xA5. The control fields are bit 6 (watchdog mode), bit 5 (timer enable) and bits [SEL_W-1:0] (divider select). A read returns these fields, and every other bit reads 0. Any other key leaves the fields unchanged.
- R3: A write to address 1 with wdata[15:8] equal to 0x5A loads wdata[7:0] into the counter, which then reads back on rdata[7:0]. Any other key leaves the counter unchanged.
- R4: A write to address 2 with wdata[15:8] equal to 0x5A sets the reset-enable bit from wdata[6]. A read of address 2 returns reset-enable on bit 6 and the overflow flag on bit 7, and all other bits read 0. Any other key leaves the reset-enable bit unchanged.
- R5: While the timer is enabled with select s, the counter rises by one every D(s) cycles, where D is the divider given above. The first step lands D(s) clock edges after the edge that enabled the timer.
- R6: While timer enable is 0, the counter holds its value.
- R7: In watchdog mode, the 255-to-0 step sets the overflow flag. The flag stays set until it is cleared as described in R9.
- R8: On that overflow, `wdt_rst` goes high from the next cycle for exactly RST_CYCLES cycles if reset-enable is 1. If reset-enable is 0, `wdt_rst` stays low.
- R9: Writing the exact word 0xA500 to address 2 clears the overflow flag, but only if address 2 was read earlier while the flag was set. Without such a read the write has no effect, and other words with key 0xA5 never clear the flag.
- R10: Loading 255 with watchdog mode, timer enable, reset-enable and select 0 all set raises `wdt_rst` one edge after the control write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register address (0 control, 1 counter, 2 reset configuration/status) |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| rd_en | input | 1 | Read strobe; a read of address 2 with the flag set arms the clear |
| wdata | input | 16 | Write data, key in [15:8] |
| rdata | output | 16 | Read data, combinational from the addressed register while rd_en is high, otherwise 0 |
| wdt_rst | output | 1 | System reset pulse |

## Verification
Register writes are sampled on the rising edge, and `rdata` is combinational. A read issued one half-cycle after a write therefore returns the new value, and the bench compares each read 1 ns after the falling edge that raised the strobe. Counter values are predicted by counting edges from the enabling write: a step every D(s) edges, with the step on the disabling edge itself included when a tick lands there. The reset pulse is sampled on each falling edge after the overflow edge. The bench expects it low on the sample right after the enabling write, high on the next RST_CYCLES samples, and low again on the sample after those.

// File: rtl/kw_watchdog_pkg.sv
package kw_watchdog_pkg;

   localparam int CNT_W = 8;
   localparam int DATA_W = 16;

   localparam logic [7:0] KEY_CTRL = 8'hA5;
   localparam logic [7:0] KEY_CNT = 8'h5A;
   localparam logic [7:0] KEY_RSTCFG = 8'h5A;
   localparam logic [15:0] CLEAR_WORD = 16'hA500;

   localparam int CTRL_WD_BIT = 6;
   localparam int CTRL_EN_BIT = 5;
   localparam int RST_EN_BIT = 6;
   localparam int RST_OVF_BIT = 7;

   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_CNT = 2'd1,
      REG_RST = 2'd2
   } reg_sel_e;

endpackage

// File: rtl/kw_prescaler.sv
module kw_prescaler #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o
);
   localparam int PW = (SEL_W == 3) ? 14 : 22;

   logic [PW-1:0] pcnt;
   logic [PW-1:0] mask;
   logic [4:0]    lg;

   generate
      if (SEL_W == 3) begin : g_sel3
         assign lg = (sel_i == 3'd7) ? 5'd14 : {1'b0, sel_i, 1'b0};
      end else begin : g_sel4
         assign lg = (sel_i == 4'hF) ? 5'd22 : {1'b0, sel_i};
      end
   endgenerate

   always_comb mask = ~({PW{1'b1}} << lg);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pcnt <= '0;
      else if (!en_i) pcnt <= '0;
      else            pcnt <= pcnt + 1'b1;
   end

   assign tick_o = en_i && ((pcnt & mask) == mask);

   AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (pcnt == '0));   // R6

endmodule

// File: rtl/kw_upcounter.sv
module kw_upcounter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         tick_i,
   output logic [W-1:0] cnt_o,
   output logic         wrap_o
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_o <= '0;
      else if (load_i) cnt_o <= load_val_i;
      else if (tick_i) cnt_o <= cnt_o + 1'b1;
   end

   assign wrap_o = tick_i && !load_i && (cnt_o == TOP);

   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !tick_i) |=> $stable(cnt_o));   // R6
   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_o |=> (cnt_o == '0));   // R7

endmodule

// File: rtl/kw_rst_pulse.sv
module kw_rst_pulse #(
   parameter int CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire_i,
   output logic pulse_o
);
   localparam int RCW = $clog2(CYCLES + 1);
   localparam logic [RCW-1:0] LOADV = RCW'(CYCLES);

   logic [RCW-1:0] rcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              rcnt <= '0;
      else if (fire_i)         rcnt <= LOADV;
      else if (rcnt != '0)     rcnt <= rcnt - 1'b1;
   end

   assign pulse_o = (rcnt != '0);

   AST_RST_FROM_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_o) |-> $past(fire_i));   // R8

endmodule

// File: rtl/kw_watchdog.sv
module kw_watchdog
   import kw_watchdog_pkg::*;
#(
   parameter int SEL_W = 3,
   parameter int RST_CYCLES = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  addr,
   input  logic        wr_en,
   input  logic        rd_en,
   input  logic [15:0] wdata,
   output logic [15:0] rdata,
   output logic        wdt_rst
);
   generate
      if (!(SEL_W == 3 || SEL_W == 4)) begin : g_bad_sel
         $error("kw_watchdog: SEL_W must be 3 or 4");
      end
      if (RST_CYCLES < 1) begin : g_bad_len
         $error("kw_watchdog: RST_CYCLES must be at least 1");
      end
   endgenerate

   localparam int PAD_W = 5 - SEL_W;

   logic             wd_mode, tmr_en, rst_ena, ovf, armed;
   logic [SEL_W-1:0] sel;
   logic [CNT_W-1:0] cnt;
   logic             tick, wrap;
   logic             wr_ctrl, wr_cnt, wr_rcfg, clr_cmd, rd_rst;
   logic             ovf_evt, fire;
   logic [7:0]       ctrl_rd;

   assign wr_ctrl = wr_en && (addr == REG_CTRL) && (wdata[15:8] == KEY_CTRL);
   assign wr_cnt  = wr_en && (addr == REG_CNT)  && (wdata[15:8] == KEY_CNT);
   assign wr_rcfg = wr_en && (addr == REG_RST)  && (wdata[15:8] == KEY_RSTCFG);
   assign clr_cmd = wr_en && (addr == REG_RST)  && (wdata == CLEAR_WORD);
   assign rd_rst  = rd_en && (addr == REG_RST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wd_mode <= 1'b0;
         tmr_en  <= 1'b0;
         sel     <= '0;
      end else if (wr_ctrl) begin
         wd_mode <= wdata[CTRL_WD_BIT];
         tmr_en  <= wdata[CTRL_EN_BIT];
         sel     <= wdata[SEL_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rst_ena <= 1'b0;
      else if (wr_rcfg) rst_ena <= wdata[RST_EN_BIT];
   end

   kw_prescaler #(.SEL_W(SEL_W)) u_presc (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (tmr_en),
      .sel_i  (sel),
      .tick_o (tick)
   );

   kw_upcounter #(.W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (wr_cnt),
      .load_val_i (wdata[CNT_W-1:0]),
      .tick_i     (tick),
      .cnt_o      (cnt),
      .wrap_o     (wrap)
   );

   assign ovf_evt = wrap && wd_mode;
   assign fire    = ovf_evt && rst_ena;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf   <= 1'b0;
         armed <= 1'b0;
      end else begin
         if (ovf_evt)              ovf <= 1'b1;
         else if (clr_cmd && armed) ovf <= 1'b0;

         if (clr_cmd && armed)     armed <= 1'b0;
         else if (rd_rst && ovf)   armed <= 1'b1;
      end
   end

   kw_rst_pulse #(.CYCLES(RST_CYCLES)) u_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire_i  (fire),
      .pulse_o (wdt_rst)
   );

   generate
      if (PAD_W > 0) begin : g_pad
         assign ctrl_rd = {1'b0, wd_mode, tmr_en, {PAD_W{1'b0}}, sel};
      end else begin : g_nopad
         assign ctrl_rd = {1'b0, wd_mode, tmr_en, sel};
      end
   endgenerate

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         case (addr)
            REG_CTRL: rdata = {8'h00, ctrl_rd};
            REG_CNT:  rdata = {{(16-CNT_W){1'b0}}, cnt};
            REG_RST:  rdata = {8'h00, ovf, rst_ena, 6'b0};
            default:  rdata = '0;
         endcase
      end
   end

   AST_CTRL_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == REG_CTRL && wdata[15:8] != KEY_CTRL)
      |=> $stable({wd_mode, tmr_en, sel}));   // R2
   AST_CNT_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == REG_CNT && wdata[15:8] != KEY_CNT && !tmr_en)
      |=> $stable(cnt));   // R3
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !clr_cmd) |=> ovf);   // R7
   AST_CLR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ovf) |-> $past(armed));   // R9
   AST_NO_RST_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !rst_ena && !wdt_rst) |=> !wdt_rst);   // R8

endmodule

// File: tb/kw_watchdog_tb.sv
module kw_watchdog_tb;
   localparam int CLK_PERIOD = 10;
   localparam int RST_CYC = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        wdt_rst;

   int checks = 0;
   int errors = 0;
   int rst_hi = 0;
   bit done = 0;

   logic [15:0] exp_q[$];
   string       tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   kw_watchdog #(.SEL_W(3), .RST_CYCLES(RST_CYC)) u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .wdt_rst(wdt_rst)
   );

   always @(posedge clk) if (wdt_rst) rst_hi++;

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      #1;
      if (rd_en) begin
         if (exp_q.size() == 0) chk("MON unexpected read", rdata, 16'hxxxx);
         else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
   end

   task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [1:0] a, input logic [15:0] exp, input string tag);
      @(negedge clk);
      exp_q.push_back(exp); tag_q.push_back(tag);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   initial begin
      int hi0;
      repeat (5) @(posedge clk);
      @(negedge clk);
      chk("R1 rst low in reset", {15'b0, wdt_rst}, 16'h0);
      rst_n = 1'b1;
      bus_rd(2'd0, 16'h0000, "R1 ctrl reset");
      bus_rd(2'd1, 16'h0000, "R1 cnt reset");
      bus_rd(2'd2, 16'h0000, "R1 rstcfg reset");

      // R2 control key
      bus_wr(2'd0, 16'h1260);
      bus_rd(2'd0, 16'h0000, "R2 bad key ignored");
      bus_wr(2'd0, 16'hA543);
      bus_rd(2'd0, 16'h0043, "R2 keyed write");
      bus_wr(2'd0, 16'hA59B);
      bus_rd(2'd0, 16'h0003, "R2 unused bits read 0");
      bus_wr(2'd0, 16'hA500);

      // R3 counter key
      bus_wr(2'd1, 16'h5A10);
      bus_rd(2'd1, 16'h0010, "R3 keyed load");
      bus_wr(2'd1, 16'hA511);
      bus_rd(2'd1, 16'h0010, "R3 bad key ignored");

      // R4 reset config key
      bus_wr(2'd2, 16'h1240);
      bus_rd(2'd2, 16'h0000, "R4 bad key ignored");
      bus_wr(2'd2, 16'h5A40);
      bus_rd(2'd2, 16'h0040, "R4 enable set");
      bus_wr(2'd2, 16'h5A00);
      bus_rd(2'd2, 16'h0000, "R4 enable cleared");

      // R5 divide by 4 (sel 1), then R6 stop
      bus_wr(2'd1, 16'h5A00);
      bus_wr(2'd0, 16'hA521);
      repeat (40) @(posedge clk);
      bus_rd(2'd1, 16'h000A, "R5 div4 after 40 edges");
      bus_wr(2'd0, 16'hA501);
      repeat (30) @(posedge clk);
      bus_rd(2'd1, 16'h000A, "R6 held after stop");

      // R5 divide by 1 (sel 0), then R6 stop with tick on stop edge
      bus_wr(2'd1, 16'h5A00);
      bus_wr(2'd0, 16'hA520);
      repeat (5) @(posedge clk);
      bus_rd(2'd1, 16'h0005, "R5 div1 after 5 edges");
      bus_wr(2'd0, 16'hA500);
      repeat (20) @(posedge clk);
      bus_rd(2'd1, 16'h0008, "R6 held after stop div1");

      // R7/R8/R9: overflow with reset disabled
      hi0 = rst_hi;
      bus_wr(2'd1, 16'h5AFE);
      bus_wr(2'd0, 16'hA560);
      repeat (4) @(posedge clk);
      bus_wr(2'd0, 16'hA540);
      repeat (20) @(posedge clk);
      chk("R8 no pulse when disabled", 16'(rst_hi - hi0), 16'h0);
      bus_wr(2'd2, 16'hA500);
      bus_rd(2'd2, 16'h0080, "R9 clear without read ignored / R7 flag");
      bus_wr(2'd2, 16'hA501);
      bus_rd(2'd2, 16'h0080, "R9 wrong clear word ignored");
      bus_wr(2'd2, 16'hA500);
      bus_rd(2'd2, 16'h0000, "R9 armed clear");

      // R10/R8: immediate reset
      bus_wr(2'd2, 16'h5A40);
      bus_wr(2'd1, 16'h5AFF);
      bus_wr(2'd0, 16'hA560);
      chk("R10 low on enable edge", {15'b0, wdt_rst}, 16'h0);
      for (int i = 0; i < RST_CYC; i++) begin
         @(negedge clk);
         chk(i == 0 ? "R10 reset after one tick" : "R8 pulse high",
             {15'b0, wdt_rst}, 16'h1);
      end
      @(negedge clk);
      chk("R8 pulse length end", {15'b0, wdt_rst}, 16'h0);
      bus_wr(2'd0, 16'hA500);
      bus_rd(2'd2, 16'h00C0, "R7 flag after reset overflow");

      repeat (3) @(posedge clk);
      chk("MON queue drained", 16'(exp_q.size()), 16'h0);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog timeout");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule